// File: doc/BRIEF.md
# Per-Channel Gate and Fault Supervisor

This block supervises one high-side output channel of a gate driver. It merges a discrete input pin and a serial gate bit into one gate request. It removes that request while the enable input is low or while either supply undervoltage flag is set. It also removes it while a latched load fault calls for the channel to be disabled. The result is the gate enable that the analog driver stage uses.

The block runs a blanking timer after every change of the effective gate state, in both directions, with a window picked by a two-bit code. When the window has expired it evaluates digital comparator inputs that belong to the current state. While the gate is on it checks for a short to ground through a short persistence filter. While the gate is off it checks for a short to battery and for an open load. Faults latch until a per-channel clear strobe or the master reset removes them. The off-state faults can be masked so that they no longer disable the gate. A short to ground always disables it. All timing counts a free-running tick strobe, which is nominally 4 MHz.

Top module: `gate_fault_supervisor`

## Requirements
- R1: With the enable input high, no undervoltage flag set and no disabling fault, `gate_on` equals `in_pin | reg_gate` in the same cycle.
- R2: While `drv_en` is low, `gate_on` is 0 whatever the gate request is.
- R3: While `cp_uv` or `vdd_uv` is 1, `gate_on` is 0 and none of the three fault flags can become set.
- R4: Each change of `gate_on` restarts a blanking window of 12, 20, 32 or 56 ticks for `blank_sel` codes 0, 1, 2 and 3, and fault evaluation in the new state starts only after the window. With one tick per clock and a comparator that is already asserted, an off-state flag sets on the (window+2)-th rising edge after the change.
- R5: A short-to-ground flag latches only while the gate is on and blanking has expired, after `stg_cmp` has been high on 4 consecutive ticks. A shorter burst leaves no trace. Once the flag latches, `gate_on` drops to 0.
- R6: `mask_off` has no effect on a latched short-to-ground flag: the gate stays off.
- R7: The short-to-battery and open-load flags latch only while the gate is off and blanking has expired, each from its own comparator. The blanking window is the same as after a turn-on.
- R8: A latched short-to-battery or open-load flag forces `gate_on` to 0 while `mask_off` is 0. Setting `mask_off` lets the gate follow its request again but does not clear the flag.
- R9: A one-cycle `clr` clears all three flags on that edge. The gate then follows its inputs again, and a fault that is still present latches again.
- R10: `fault_req` is 1 whenever any of the three flags is set, including a masked one.
- R11: After reset all three flags and `fault_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low master reset; clears all flags |
| tick | input | 1 | Timebase strobe, one pulse per timer tick |
| in_pin | input | 1 | Discrete gate input |
| reg_gate | input | 1 | Serial gate-on bit |
| drv_en | input | 1 | Enable; low forces the gate off |
| cp_uv | input | 1 | Charge-pump undervoltage flag |
| vdd_uv | input | 1 | Logic-supply undervoltage flag |
| blank_sel | input | 2 | Blanking window code |
| mask_off | input | 1 | Mask for off-state faults |
| clr | input | 1 | Per-channel fault clear strobe |
| stg_cmp | input | 1 | Short-to-ground comparator output |
| stb_cmp | input | 1 | Short-to-battery comparator output |
| ol_cmp | input | 1 | Open-load comparator output |
| gate_on | output | 1 | Effective gate enable |
| stg_flag | output | 1 | Latched short-to-ground fault |
| stb_flag | output | 1 | Latched short-to-battery fault |
| ol_flag | output | 1 | Latched open-load fault |
| fault_req | output | 1 | Any flag set |

## Verification
The gate path is swept over all 32 combinations of pin, serial bit, enable and the two lockouts. This separates the OR of the two requests from the three kinds of override. Fault latency is measured for every blanking code and every fault type. The measured edge count confirms the window length and that turn-off uses the same window as turn-on. Holding each comparator high in the opposite gate state, and re-toggling the gate inside the window, shows that evaluation depends on the state and that the timer restarts. Short comparator bursts, mask, clear and lockout sequences separate the filter, the masking rule and the re-latch after a clear.

// File: rtl/gate_fault_supervisor.sv
module gate_fault_supervisor #(
  parameter int BLANK_T0 = 12,
  parameter int BLANK_T1 = 20,
  parameter int BLANK_T2 = 32,
  parameter int BLANK_T3 = 56,
  parameter int STG_FILT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       in_pin,
  input  logic       reg_gate,
  input  logic       drv_en,
  input  logic       cp_uv,
  input  logic       vdd_uv,
  input  logic [1:0] blank_sel,
  input  logic       mask_off,
  input  logic       clr,
  input  logic       stg_cmp,
  input  logic       stb_cmp,
  input  logic       ol_cmp,
  output logic       gate_on,
  output logic       stg_flag,
  output logic       stb_flag,
  output logic       ol_flag,
  output logic       fault_req
);

  localparam int M01  = (BLANK_T0 > BLANK_T1) ? BLANK_T0 : BLANK_T1;
  localparam int M23  = (BLANK_T2 > BLANK_T3) ? BLANK_T2 : BLANK_T3;
  localparam int BMAX = (M01 > M23) ? M01 : M23;
  localparam int CW   = $clog2(BMAX + 1);
  localparam int FW   = $clog2(STG_FILT + 1);

  logic [CW-1:0] lim, cnt;
  logic [FW-1:0] fcnt;
  logic          g_q, uv, blank_done, on_eval, off_eval, stg_set, block;

  assign uv      = cp_uv | vdd_uv;
  assign block   = stg_flag | ((stb_flag | ol_flag) & ~mask_off);
  assign gate_on = (in_pin | reg_gate) & drv_en & ~uv & ~block;

  always_comb begin
    case (blank_sel)
      2'd0:    lim = CW'(BLANK_T0);
      2'd1:    lim = CW'(BLANK_T1);
      2'd2:    lim = CW'(BLANK_T2);
      default: lim = CW'(BLANK_T3);
    endcase
  end

  assign blank_done = (gate_on == g_q) && (cnt >= lim);
  assign on_eval    = gate_on & blank_done & ~uv;
  assign off_eval   = ~gate_on & blank_done & ~uv;
  assign stg_set    = on_eval & stg_cmp & tick & (fcnt == FW'(STG_FILT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      g_q <= 1'b0;
      cnt <= '0;
    end else if (gate_on != g_q) begin
      g_q <= gate_on;
      cnt <= '0;
    end else if (tick && cnt < lim) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr || !(on_eval && stg_cmp))
      fcnt <= '0;
    else if (tick && !stg_set)
      fcnt <= fcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      stg_flag <= 1'b0;
      stb_flag <= 1'b0;
      ol_flag  <= 1'b0;
    end else begin
      if (stg_set)             stg_flag <= 1'b1;
      if (off_eval && stb_cmp) stb_flag <= 1'b1;
      if (off_eval && ol_cmp)  ol_flag  <= 1'b1;
    end
  end

  assign fault_req = stg_flag | stb_flag | ol_flag;

  AST_GATE_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!drv_en || uv) |-> !gate_on); // R2
  AST_UV_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (uv && !clr) |=> ({stg_flag, stb_flag, ol_flag} == $past({stg_flag, stb_flag, ol_flag}))); // R3
  AST_BLANK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(BMAX)); // R4
  AST_STG_ONLY_ON: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stg_flag) |-> $past(gate_on && stg_cmp)); // R5
  AST_STG_KILLS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    stg_flag |-> !gate_on); // R6
  AST_STB_ONLY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stb_flag) |-> $past(!gate_on && stb_cmp)); // R7
  AST_OL_ONLY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ol_flag) |-> $past(!gate_on && ol_cmp)); // R7
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (stg_flag && !clr) |=> stg_flag); // R9
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !fault_req); // R9

endmodule

// File: tb/gate_fault_supervisor_tb_top.sv
`timescale 1ns/1ps
module gate_fault_supervisor_tb_top;
  logic clk = 0, rst_n = 0, tick = 1, in_pin = 0, reg_gate = 0, drv_en = 1;
  logic cp_uv = 0, vdd_uv = 0, mask_off = 0, clr = 0;
  logic stg_cmp = 0, stb_cmp = 0, ol_cmp = 0;
  logic [1:0] blank_sel = 0;
  logic gate_on, stg_flag, stb_flag, ol_flag, fault_req;
  int nvec = 0, nerr = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gate_fault_supervisor dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .in_pin(in_pin), .reg_gate(reg_gate),
    .drv_en(drv_en), .cp_uv(cp_uv), .vdd_uv(vdd_uv), .blank_sel(blank_sel),
    .mask_off(mask_off), .clr(clr), .stg_cmp(stg_cmp), .stb_cmp(stb_cmp),
    .ol_cmp(ol_cmp), .gate_on(gate_on), .stg_flag(stg_flag), .stb_flag(stb_flag),
    .ol_flag(ol_flag), .fault_req(fault_req));

  function automatic int blim(int s);
    return (s == 0) ? 12 : (s == 1) ? 20 : (s == 2) ? 32 : 56;
  endfunction

  task automatic chk(string req, int act, int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; in_pin = 0; reg_gate = 0; drv_en = 1; cp_uv = 0; vdd_uv = 0;
    mask_off = 0; clr = 0; stg_cmp = 0; stb_cmp = 0; ol_cmp = 0; blank_sel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic lat(int which, output int n);
    n = -1;
    for (int k = 1; k <= 300; k++) begin
      @(posedge clk); #1;
      if ((which == 0 && stg_flag) || (which == 1 && stb_flag) || (which == 2 && ol_flag)) begin
        n = k;
        break;
      end
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    int n;
    do_reset();
    edges(2);
    chk("R11 flags after reset", {stg_flag, stb_flag, ol_flag}, 0);
    chk("R11 fault_req after reset", fault_req, 0);

    for (int v = 0; v < 32; v++) begin
      @(negedge clk);
      in_pin = v[0]; reg_gate = v[1]; drv_en = v[2]; cp_uv = v[3]; vdd_uv = v[4];
      #1;
      chk(v[3] | v[4] ? "R3 gate under lockout" : (!v[2] ? "R2 gate disabled" : "R1 gate request"),
          gate_on, (v[0] | v[1]) & v[2] & ~v[3] & ~v[4]);
    end

    for (int s = 0; s < 4; s++) begin
      for (int f = 1; f <= 2; f++) begin
        do_reset();
        blank_sel = 2'(s); in_pin = 1;
        if (f == 1) stb_cmp = 1; else ol_cmp = 1;
        edges(80);
        chk("R7 off-state fault ignored while on", f == 1 ? stb_flag : ol_flag, 0);
        @(negedge clk); in_pin = 0;
        lat(f, n);
        chk("R4 R7 turn-off blank latency", n, blim(s) + 2);
      end
      do_reset();
      blank_sel = 2'(s); stg_cmp = 1;
      edges(80);
      chk("R5 stg ignored while off", stg_flag, 0);
      @(negedge clk); in_pin = 1;
      lat(0, n);
      chk("R4 R5 turn-on blank plus filter latency", n, blim(s) + 5);
      chk("R5 gate off after stg", gate_on, 0);
    end

    do_reset();
    in_pin = 1; stb_cmp = 1;
    edges(20);
    @(negedge clk); in_pin = 0;
    edges(6);
    @(negedge clk); in_pin = 1;
    @(negedge clk); in_pin = 0;
    chk("R4 no latch inside window", stb_flag, 0);
    lat(1, n);
    chk("R4 window restarts on toggle", n, 14);

    do_reset();
    in_pin = 1;
    edges(20);
    @(negedge clk); stg_cmp = 1;
    repeat (3) @(negedge clk);
    stg_cmp = 0;
    edges(10);
    chk("R5 short burst filtered", stg_flag, 0);
    chk("R5 gate stays on", gate_on, 1);
    @(negedge clk); stg_cmp = 1;
    lat(0, n);
    chk("R5 filter length", n, 4);
    @(negedge clk); stg_cmp = 0; mask_off = 1;
    #1;
    chk("R6 mask does not release stg", gate_on, 0);
    chk("R10 fault_req with masked flag", fault_req, 1);
    @(negedge clk); clr = 1;
    edges(1);
    chk("R9 clear stg", stg_flag, 0);
    chk("R9 gate follows after clear", gate_on, 1);
    @(negedge clk); clr = 0;

    do_reset();
    stb_cmp = 1;
    edges(20);
    chk("R7 stb latched while off", stb_flag, 1);
    @(negedge clk); stb_cmp = 0; in_pin = 1;
    #1;
    chk("R8 stb disables gate", gate_on, 0);
    @(negedge clk); mask_off = 1;
    #1;
    chk("R8 mask releases gate", gate_on, 1);
    chk("R8 mask keeps flag", stb_flag, 1);
    chk("R10 fault_req masked stb", fault_req, 1);
    @(negedge clk); mask_off = 0; clr = 1;
    edges(1);
    chk("R9 clear stb", stb_flag, 0);
    chk("R10 fault_req after clear", fault_req, 0);
    @(negedge clk); clr = 0;

    do_reset();
    ol_cmp = 1;
    edges(20);
    chk("R7 ol latched", ol_flag, 1);
    @(negedge clk); clr = 1;
    edges(1);
    chk("R9 ol cleared", ol_flag, 0);
    @(negedge clk); clr = 0;
    edges(1);
    chk("R9 persistent ol relatches", ol_flag, 1);

    do_reset();
    cp_uv = 1; stb_cmp = 1; ol_cmp = 1; in_pin = 1; stg_cmp = 1;
    edges(100);
    chk("R3 no latch under charge-pump lockout", fault_req, 0);
    @(negedge clk); cp_uv = 0; vdd_uv = 1;
    edges(100);
    chk("R3 no latch under logic lockout", fault_req, 0);
    chk("R3 gate off under lockout", gate_on, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule